// File: doc/BRIEF.md
# Bit-Aligned Contactless Frame Deframer

This block sits behind a demodulator that delivers eight received bits per byte strobe, the earliest bit in bit 0. It hunts for a 16-bit sync word that may begin at any bit position. Once the word is found, it keeps that bit offset and builds every later frame byte from the tail of one input byte and the head of the next. It then captures the length byte, the payload and a two-byte CRC into a small frame buffer.

When the last CRC byte arrives, the block raises a frame-complete flag, reports the whole frame size and gives a CRC verdict. It then stays frozen until a clear. A byte-counting reply timer flags a peer that never starts a frame. Software or a sequencer reads the captured frame through a combinational read port. Addresses 0 and 1 of that port return the sync word.

Top module: `nfc_deframer`

## Requirements
- R1: The sync word 0xB24D is recognised at any of the eight bit offsets. Input bits are taken bit 0 first and shifted into the sync register from the bottom, so the first bit received ends up as the most significant bit. Read address 0 returns 0xB2 and address 1 returns 0x4D.
- R2: Zero bytes are ignored while no sync attempt is running. Any nonzero byte starts an attempt, and leading noise bits before the sync word do not prevent locking. A zero byte during an attempt abandons it, so a sync word split by an inserted zero byte is not recognised.
- R3: After lock, each frame byte is built from the next eight received bits, the first of them as the most significant bit. The first frame byte after the sync word is stored at buffer address 2 and each following byte at the next address.
- R4: The first byte after sync is a length field L that counts itself and the payload. L-1 payload bytes and then exactly two CRC bytes follow, after which frame_done rises with frame_len = L+4.
- R5: crc_ok is high only with frame_done. It is set when a CRC-16 over the length, payload and CRC bytes leaves a zero residue. The CRC uses polynomial 0x1021, start value 0x0000 and most-significant-bit-first processing, with the CRC high byte sent first.
- R6: While frame_done is high, input bytes change neither the flags, frame_len nor the buffer. A clear returns frame_done, crc_ok, frame_len and timeout to zero and restarts the sync hunt.
- R7: A byte counter restarts at each clear and counts every valid byte, saturating at its maximum. timeout is set when a byte arrives before lock and brings the count above to_limit, and it stays set until a clear. Bytes received after lock never set it.
- R8: A length field of 0, or one with L+4 greater than the buffer depth MAX_LEN, ends the frame right after the length byte, with frame_done high, crc_ok low and frame_len = L+4. A frame of exactly MAX_LEN bytes is captured in full.
- R9: After reset, frame_done, crc_ok and timeout are low and frame_len is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; restarts the hunt and drops all flags |
| in_valid | input | 1 | Strobe for in_byte |
| in_byte | input | 8 | Eight received bits, earliest in bit 0 |
| to_limit | input | TO_W | Byte count the hunt may reach before timeout |
| rd_addr | input | $clog2(MAX_LEN) | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr (combinational) |
| frame_done | output | 1 | Frame complete; held until clear |
| crc_ok | output | 1 | CRC residue zero for the completed frame |
| frame_len | output | 9 | Length field plus 4 |
| timeout | output | 1 | No lock within to_limit bytes; sticky |

## Verification
The bench builds the block with MAX_LEN = 16 and TO_W = 8. The small buffer lets a length field of 20 cross the overflow limit. It also makes the largest frame that fits (L = 12) short enough to read back byte by byte. The 8-bit limit port keeps the timeout windows to a handful of bytes, so a stall both just below and just above the limit can be driven quickly. Frames are sent at bit offsets 0, 3 and 7, behind noise and across an inserted zero byte, which exercises every path of the bit-slicing hunt.

// File: rtl/nfc_deframer_pkg.sv
package nfc_deframer_pkg;

    localparam logic [15:0] SYNC_WORD = 16'hB24D;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam int          FL_W      = 9;

    typedef enum logic [1:0] {AL_IDLE, AL_HUNT, AL_LOCK} al_phase_e;
    typedef enum logic [1:0] {FC_LEN, FC_BODY, FC_DONE} fc_phase_e;

    // One byte of CRC-16, most significant data bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/nfc_bit_aligner.sv
module nfc_bit_aligner
    import nfc_deframer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hold,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       locked,
    output logic       ob_valid,
    output logic [7:0] ob_data
);
    typedef struct packed {
        al_phase_e   ph;
        logic [15:0] sr;
        logic [7:0]  acc;
        logic [2:0]  cnt;
    } al_state_t;

    localparam al_state_t AL_RST = '{ph: AL_IDLE, sr: '0, acc: '0, cnt: '0};

    al_state_t st_q, st_d;
    logic      got;

    always_comb begin
        st_d     = st_q;
        ob_valid = 1'b0;
        ob_data  = 8'h00;
        got      = (st_q.ph == AL_LOCK);
        if (clr) begin
            st_d = AL_RST;
        end else if (in_valid && !hold) begin
            if (st_q.ph == AL_IDLE) begin
                // a fresh attempt loads all eight bits, no match possible yet
                if (in_byte != 8'h00) begin
                    st_d.ph = AL_HUNT;
                    st_d.sr = '0;
                    for (int i = 0; i < 8; i++) st_d.sr = {st_d.sr[14:0], in_byte[i]};
                end
            end else if (st_q.ph == AL_HUNT && in_byte == 8'h00) begin
                st_d.ph = AL_IDLE;
                st_d.sr = '0;
            end else begin
                // bit slice: hunt until match, then gather the remaining bits
                for (int i = 0; i < 8; i++) begin
                    if (got) begin
                        st_d.acc = {st_d.acc[6:0], in_byte[i]};
                        if (st_d.cnt == 3'd7) begin
                            ob_valid = 1'b1;
                            ob_data  = st_d.acc;
                        end
                        st_d.cnt = st_d.cnt + 3'd1;
                    end else begin
                        st_d.sr = {st_d.sr[14:0], in_byte[i]};
                        if (st_d.sr == SYNC_WORD) begin
                            got      = 1'b1;
                            st_d.cnt = 3'd0;
                        end
                    end
                end
                if (got) st_d.ph = AL_LOCK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AL_RST;
        else        st_q <= st_d;
    end

    assign locked = (st_q.ph == AL_LOCK);

endmodule

// File: rtl/nfc_frame_ctrl.sv
module nfc_frame_ctrl
    import nfc_deframer_pkg::*;
#(
    parameter int MAX_LEN = 260,
    parameter int AW      = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ob_valid,
    input  logic [7:0]      ob_data,
    output logic            done,
    output logic            crc_ok,
    output logic [FL_W-1:0] frame_len,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [7:0]      wr_data
);
    localparam logic [FL_W-1:0] CAP = FL_W'(MAX_LEN);

    typedef struct packed {
        fc_phase_e       ph;
        logic [8:0]      rem;
        logic [AW-1:0]   wptr;
        logic [15:0]     crc;
        logic [FL_W-1:0] flen;
        logic            ok;
    } fc_state_t;

    localparam fc_state_t FC_RST = '{ph: FC_LEN, rem: '0, wptr: AW'(2), crc: '0, flen: '0, ok: 1'b0};

    fc_state_t   st_q, st_d;
    logic [15:0] crc_n;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.wptr;
        wr_data = ob_data;
        crc_n   = crc_step(st_q.crc, ob_data);
        if (clr) begin
            st_d = FC_RST;
        end else if (ob_valid && st_q.ph != FC_DONE) begin
            wr_en     = 1'b1;
            st_d.crc  = crc_n;
            st_d.wptr = st_q.wptr + AW'(1);
            if (st_q.ph == FC_LEN) begin
                st_d.flen = {1'b0, ob_data} + 9'd4;
                if (ob_data == 8'h00 || ({1'b0, ob_data} + 9'd4) > CAP) begin
                    st_d.ph = FC_DONE;
                    st_d.ok = 1'b0;
                end else begin
                    st_d.rem = {1'b0, ob_data} + 9'd1;
                    st_d.ph  = FC_BODY;
                end
            end else begin
                st_d.rem = st_q.rem - 9'd1;
                if (st_q.rem == 9'd1) begin
                    st_d.ph = FC_DONE;
                    st_d.ok = (crc_n == 16'h0000);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FC_RST;
        else        st_q <= st_d;
    end

    assign done      = (st_q.ph == FC_DONE);
    assign crc_ok    = st_q.ok;
    assign frame_len = st_q.flen;

endmodule

// File: rtl/nfc_frame_buf.sv
module nfc_frame_buf #(
    parameter int DEPTH = 260,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // sync bytes are constant and never stored
    always_comb begin
        if (rd_addr == AW'(0))          rd_data = 8'hB2;
        else if (rd_addr == AW'(1))     rd_data = 8'h4D;
        else if (int'(rd_addr) < DEPTH) rd_data = mem[rd_addr];
        else                            rd_data = 8'h00;
    end

endmodule

// File: rtl/nfc_reply_timer.sv
module nfc_reply_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic            locked,
    input  logic [TO_W-1:0] to_limit,
    output logic            timeout
);
    typedef struct packed {
        logic [TO_W-1:0] cnt;
        logic            fired;
    } to_state_t;

    to_state_t       st_q, st_d;
    logic [TO_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + TO_W'(1);
        if (clr) begin
            st_d = '0;
        end else if (in_valid) begin
            st_d.cnt = cnt_inc;
            if (!locked && cnt_inc > to_limit) st_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timeout = st_q.fired;

endmodule

// File: rtl/nfc_deframer.sv
module nfc_deframer
    import nfc_deframer_pkg::*;
#(
    parameter  int MAX_LEN = 260,
    parameter  int TO_W    = 16,
    localparam int AW      = $clog2(MAX_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic [TO_W-1:0] to_limit,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic            frame_done,
    output logic            crc_ok,
    output logic [8:0]      frame_len,
    output logic            timeout
);
    logic          locked;
    logic          ob_valid;
    logic [7:0]    ob_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    nfc_bit_aligner u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .hold     (frame_done),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .locked   (locked),
        .ob_valid (ob_valid),
        .ob_data  (ob_data)
    );

    nfc_frame_ctrl #(.MAX_LEN(MAX_LEN), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .ob_valid  (ob_valid),
        .ob_data   (ob_data),
        .done      (frame_done),
        .crc_ok    (crc_ok),
        .frame_len (frame_len),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    nfc_frame_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    nfc_reply_timer #(.TO_W(TO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .locked   (locked),
        .to_limit (to_limit),
        .timeout  (timeout)
    );

endmodule

// File: rtl/nfc_deframer_chk.sv
module nfc_deframer_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          in_valid,
    input logic          locked,
    input logic          frame_done,
    input logic          crc_ok,
    input logic          timeout,
    input logic [8:0]    frame_len,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data
);
    AST_SYNC_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == AW'(0) |-> rd_data == 8'hB2); // R1

    AST_SYNC_LO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == AW'(1) |-> rd_data == 8'h4D); // R1

    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> frame_len >= 9'd4); // R4

    AST_CRC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> frame_done); // R5

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !clr |=> frame_done && $stable(frame_len) && $stable(crc_ok)); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !frame_done && !crc_ok && !timeout && frame_len == 9'd0); // R6

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && !clr |=> timeout); // R7

    AST_TIMEOUT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(in_valid && !locked)); // R7

endmodule

bind nfc_deframer nfc_deframer_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .in_valid   (in_valid),
    .locked     (locked),
    .frame_done (frame_done),
    .crc_ok     (crc_ok),
    .timeout    (timeout),
    .frame_len  (frame_len),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
);

// File: tb/tb_nfc_deframer.sv
module tb_nfc_deframer;
    localparam int MAXL = 16;
    localparam int TOW  = 8;
    localparam int AWB  = $clog2(MAXL);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr = 1'b0;
    logic           in_valid = 1'b0;
    logic [7:0]     in_byte = 8'h00;
    logic [TOW-1:0] to_limit = '1;
    logic [AWB-1:0] rd_addr = '0;
    logic [7:0]     rd_data;
    logic           frame_done, crc_ok, timeout;
    logic [8:0]     frame_len;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic       sb [0:1023];
    int         nb;
    logic [7:0] fb [0:63];
    int         fl;

    always #4 clk = ~clk;

    nfc_deframer #(.MAX_LEN(MAXL), .TO_W(TOW)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_byte(in_byte),
        .to_limit(to_limit), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_done(frame_done), .crc_ok(crc_ok), .frame_len(frame_len), .timeout(timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int j = 0; j < n; j++)
            for (int i = 7; i >= 0; i--)
                c = (c[15] ^ fb[j][i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
        return c;
    endfunction

    task automatic make_frame(input int len, input int seed, input bit corrupt);
        logic [15:0] c;
        fb[0] = len[7:0];
        for (int j = 1; j < len; j++) fb[j] = 8'((seed + j * 37) & 8'hFF);
        c = ref_crc(len);
        fb[len] = c[15:8];
        fb[len + 1] = c[7:0];
        fl = len + 2;
        if (corrupt) fb[1] = fb[1] ^ 8'h01;
    endtask

    task automatic push_zeros(input int k);
        for (int i = 0; i < k; i++) begin sb[nb] = 1'b0; nb++; end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin sb[nb] = b[i]; nb++; end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_stream();
        for (int n = 0; n < (nb + 7) / 8; n++) begin
            logic [7:0] b;
            for (int i = 0; i < 8; i++) b[i] = (8 * n + i < nb) ? sb[8 * n + i] : 1'b0;
            send_byte(b);
        end
    endtask

    task automatic stream_frame(input int off, input int nbytes);
        nb = 0;
        push_zeros(off);
        push_byte(8'hB2);
        push_byte(8'h4D);
        for (int j = 0; j < nbytes; j++) push_byte(fb[j]);
        send_stream();
    endtask

    task automatic do_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic check_buffer(input string req, input int n);
        for (int a = 0; a < n; a++) begin
            rd_addr = AWB'(a);
            #1;
            chk(req, rd_data, (a == 0) ? 8'hB2 : (a == 1) ? 8'h4D : fb[a - 2]);
        end
    endtask

    task automatic t_reset();
        chk("R9 done", frame_done, 0);
        chk("R9 crc_ok", crc_ok, 0);
        chk("R9 timeout", timeout, 0);
        chk("R9 frame_len", frame_len, 0);
    endtask

    task automatic t_offsets();
        int offs [3] = '{0, 3, 7};
        foreach (offs[k]) begin
            do_clr();
            make_frame(5, 11 * k + 3, 1'b0);
            stream_frame(offs[k], fl);
            chk("R4 done", frame_done, 1);
            chk("R4 frame_len", frame_len, 9);
            chk("R5 crc_ok good", crc_ok, 1);
            check_buffer("R1 R3 buffer", 9);
        end
    endtask

    task automatic t_max_fit();
        do_clr();
        make_frame(12, 90, 1'b0);
        stream_frame(5, fl);
        chk("R8 fit done", frame_done, 1);
        chk("R8 fit len", frame_len, 16);
        chk("R8 fit crc", crc_ok, 1);
        check_buffer("R8 fit buffer", 16);
    endtask

    task automatic t_bad_crc();
        do_clr();
        make_frame(6, 7, 1'b1);
        stream_frame(2, fl);
        chk("R5 bad done", frame_done, 1);
        chk("R5 bad crc_ok", crc_ok, 0);
    endtask

    task automatic t_noise();
        do_clr();
        make_frame(4, 55, 1'b0);
        nb = 0;
        push_zeros(16);
        push_byte(8'hFF);
        push_zeros(2);
        push_byte(8'hB2);
        push_byte(8'h4D);
        for (int j = 0; j < fl; j++) push_byte(fb[j]);
        send_stream();
        chk("R2 noise done", frame_done, 1);
        chk("R2 noise crc", crc_ok, 1);
        check_buffer("R2 noise buffer", 8);
        // sync split by a zero byte: must not lock
        do_clr();
        send_byte(8'hD0);
        send_byte(8'h00);
        send_byte(8'h24);
        send_byte(8'h0B);
        send_byte(8'hFF);
        send_byte(8'hFF);
        send_byte(8'hFF);
        chk("R2 split no lock", frame_done, 0);
    endtask

    task automatic t_bad_len();
        do_clr();
        fb[0] = 8'd0;
        stream_frame(1, 1);
        chk("R8 zero len done", frame_done, 1);
        chk("R8 zero len flen", frame_len, 4);
        chk("R8 zero len crc", crc_ok, 0);
        do_clr();
        fb[0] = 8'd20;
        fb[1] = 8'h33;
        fb[2] = 8'h44;
        stream_frame(4, 3);
        chk("R8 overflow done", frame_done, 1);
        chk("R8 overflow flen", frame_len, 24);
        chk("R8 overflow crc", crc_ok, 0);
    endtask

    task automatic t_ignore();
        do_clr();
        make_frame(5, 1, 1'b0);
        stream_frame(0, fl);
        chk("R6 first done", frame_done, 1);
        make_frame(3, 200, 1'b0);
        stream_frame(0, fl);
        chk("R6 ignored len", frame_len, 9);
        chk("R6 ignored crc", crc_ok, 1);
        rd_addr = AWB'(2);
        #1;
        chk("R6 ignored buffer", rd_data, 5);
        do_clr();
        chk("R6 clr done", frame_done, 0);
        chk("R6 clr len", frame_len, 0);
        chk("R6 clr crc", crc_ok, 0);
    endtask

    task automatic t_timeout();
        to_limit = 8'd5;
        do_clr();
        for (int i = 0; i < 5; i++) send_byte(8'h00);
        chk("R7 at limit", timeout, 0);
        send_byte(8'h00);
        chk("R7 above limit", timeout, 1);
        send_byte(8'h00);
        chk("R7 sticky", timeout, 1);
        do_clr();
        chk("R7 clr", timeout, 0);
        to_limit = 8'd3;
        do_clr();
        make_frame(12, 4, 1'b0);
        stream_frame(0, fl);
        chk("R7 locked frame done", frame_done, 1);
        chk("R7 locked no timeout", timeout, 0);
        to_limit = '1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_offsets();
        t_max_fit();
        t_bad_crc();
        t_noise();
        t_bad_len();
        t_ignore();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule